// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a virtual address that missed in the translation buffer. It splits a 32-bit virtual address into a 10-bit super index, a 10-bit second-level index and a 12-bit page offset. It then reads the super-level table through a single memory read port. A super entry that is present gives the frame of a second-level table, and the walker reads the entry for the page from that table. The result is either a translation, meaning a physical page number with access rights and a dirty flag, or an abort.

A super entry that is not present ends the walk at once. Because of this, second-level tables only need to exist for the super entries that are present. The memory port uses a one-cycle request pulse and a read-valid strobe, and its latency may vary. The result goes to the buffer refill logic, along with the full physical address formed from the page number and the untranslated offset.

Table words use this layout: bit 0 is present, bits 3:1 are access rights, bit 4 is dirty, and bits 31:12 hold the frame number. In a super entry the frame number points to a second-level table. In a second-level entry it is the physical page.

Top module: `ptw_walker`

## Requirements
- R1: While reset is high and in the cycle after it, `req_ready` is 1, and `mem_req`, `walk_done` and `walk_abort` are 0.
- R2: The first read of a walk goes to address {`table_base`[19:0], vaddr[31:22], 2'b00}.
- R3: If the super word returned has bit 0 clear, the walk aborts with `abort_second` = 0, and no second read is issued.
- R4: The second read goes to address {super word[31:12], vaddr[21:12], 2'b00}.
- R5: If the second-level word has bit 0 clear, the walk aborts with `abort_second` = 1.
- R6: If the second-level word has bit 0 set, `walk_done` reports `out_ppn` = word[31:12], `out_rights` = word[3:1], `out_dirty` = word[4] and `out_paddr` = {word[31:12], vaddr[11:0]}.
- R7: Each walk raises exactly one of `walk_done` or `walk_abort`, and it stays high for exactly one cycle. The two are never high together.
- R8: A request is taken only when `req_ready` is 1. A `req_valid` that arrives during a walk starts no read and does not change the result.
- R9: `mem_req` is a single-cycle pulse for each read. `mem_addr` holds steady until `mem_rvalid` arrives, whatever the latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk for `req_vaddr` |
| req_vaddr | input | 32 | Virtual address that missed |
| req_ready | output | 1 | Walker idle, request accepted |
| table_base | input | 20 | Frame of the super-level table |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Read address, held until read-valid |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Table word read |
| walk_done | output | 1 | Translation ready pulse |
| walk_abort | output | 1 | Page-fault pulse |
| abort_second | output | 1 | Abort came from the second level |
| out_ppn | output | 20 | Physical page number |
| out_rights | output | 3 | Access rights of the page |
| out_dirty | output | 1 | Dirty flag of the page |
| out_paddr | output | 32 | Physical address of the missed access |

## Verification
A wrong state in the walker shows at the ports within the same walk. A wrong transition produces an extra or a missing `mem_req` pulse, or a read at the wrong address, which shows as soon as the read is issued. A wrong decode shows as a wrong outcome or fields at the single result pulse. A state that is never left shows as a walk with no result pulse, and a stuck result state shows as a pulse longer than one cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W     = 32;
    localparam int IDX_W    = 10;
    localparam int OFF_W    = 12;
    localparam int WORD_W   = 32;
    localparam int PN_W     = VA_W - OFF_W;
    localparam int RIGHTS_W = 3;
    localparam int BYTE_SH  = $clog2(WORD_W / 8);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SUP,
        ST_WT_SUP,
        ST_RD_SEC,
        ST_WT_SEC,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef struct packed {
        logic [PN_W-1:0]     frame;
        logic                dirty;
        logic [RIGHTS_W-1:0] rights;
        logic                present;
    } pte_t;

    function automatic pte_t unpack_pte(input logic [WORD_W-1:0] w);
        pte_t p;
        p.present = w[0];
        p.rights  = w[RIGHTS_W:1];
        p.dirty   = w[RIGHTS_W+1];
        p.frame   = w[WORD_W-1 -: PN_W];
        return p;
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [VA_W-1:0] vaddr,
    input  logic [PN_W-1:0] base_frame,
    input  logic [PN_W-1:0] sec_frame,
    output logic [VA_W-1:0] sup_addr,
    output logic [VA_W-1:0] sec_addr
);
    localparam int SUP_LSB = OFF_W + IDX_W;

    logic [IDX_W-1:0] sup_idx;
    logic [IDX_W-1:0] sec_idx;

    assign sup_idx  = vaddr[SUP_LSB +: IDX_W];
    assign sec_idx  = vaddr[OFF_W +: IDX_W];
    assign sup_addr = {base_frame, sup_idx, {BYTE_SH{1'b0}}};
    assign sec_addr = {sec_frame,  sec_idx, {BYTE_SH{1'b0}}};
endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec
    import ptw_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output pte_t              pte
);
    assign pte = unpack_pte(word);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [VA_W-1:0]     req_vaddr,
    output logic                req_ready,
    input  logic [PN_W-1:0]     table_base,
    output logic                mem_req,
    output logic [VA_W-1:0]     mem_addr,
    input  logic                mem_rvalid,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                walk_done,
    output logic                walk_abort,
    output logic                abort_second,
    output logic [PN_W-1:0]     out_ppn,
    output logic [RIGHTS_W-1:0] out_rights,
    output logic                out_dirty,
    output logic [VA_W-1:0]     out_paddr
);
    walk_state_e     state_q;
    logic [VA_W-1:0] vaddr_q;
    logic [PN_W-1:0] sec_frame_q;
    pte_t            res_q;
    logic            abort_sec_q;

    logic [VA_W-1:0] sup_addr;
    logic [VA_W-1:0] sec_addr;
    pte_t            rd_pte;

    ptw_addr_gen u_addr (
        .vaddr      (vaddr_q),
        .base_frame (table_base),
        .sec_frame  (sec_frame_q),
        .sup_addr   (sup_addr),
        .sec_addr   (sec_addr)
    );

    ptw_entry_dec u_dec (
        .word (mem_rdata),
        .pte  (rd_pte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            vaddr_q     <= '0;
            sec_frame_q <= '0;
            res_q       <= '0;
            abort_sec_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr;
                        state_q <= ST_RD_SUP;
                    end
                end
                ST_RD_SUP: state_q <= ST_WT_SUP;
                ST_WT_SUP: begin
                    if (mem_rvalid) begin
                        if (rd_pte.present) begin
                            sec_frame_q <= rd_pte.frame;
                            state_q     <= ST_RD_SEC;
                        end else begin
                            abort_sec_q <= 1'b0;
                            state_q     <= ST_FAULT;
                        end
                    end
                end
                ST_RD_SEC: state_q <= ST_WT_SEC;
                ST_WT_SEC: begin
                    if (mem_rvalid) begin
                        if (rd_pte.present) begin
                            res_q   <= rd_pte;
                            state_q <= ST_DONE;
                        end else begin
                            abort_sec_q <= 1'b1;
                            state_q     <= ST_FAULT;
                        end
                    end
                end
                ST_DONE:  state_q <= ST_IDLE;
                ST_FAULT: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_addr = sup_addr;
        if (state_q == ST_RD_SEC || state_q == ST_WT_SEC) begin
            mem_addr = sec_addr;
        end
    end

    assign req_ready    = (state_q == ST_IDLE);
    assign mem_req      = (state_q == ST_RD_SUP) || (state_q == ST_RD_SEC);
    assign walk_done    = (state_q == ST_DONE);
    assign walk_abort   = (state_q == ST_FAULT);
    assign abort_second = abort_sec_q;
    assign out_ppn      = res_q.frame;
    assign out_rights   = res_q.rights;
    assign out_dirty    = res_q.dirty;
    assign out_paddr    = {res_q.frame, vaddr_q[OFF_W-1:0]};

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
    import ptw_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input walk_state_e     state_q,
    input logic            req_ready,
    input logic            mem_req,
    input logic [VA_W-1:0] mem_addr,
    input logic            mem_rvalid,
    input logic            walk_done,
    input logic            walk_abort
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (req_ready && !mem_req && !walk_done && !walk_abort));

    // R7
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        !(walk_done && walk_abort));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        walk_done |=> !walk_done && !walk_abort);

    // R7
    abort_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        walk_abort |=> !walk_abort && !walk_done);

    // R8
    busy_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);

    // R9
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req || ((state_q == ST_WT_SUP || state_q == ST_WT_SEC) && !mem_rvalid))
            |=> $stable(mem_addr));
endmodule

bind ptw_walker ptw_walker_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .state_q    (state_q),
    .req_ready  (req_ready),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .walk_done  (walk_done),
    .walk_abort (walk_abort)
);

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic        req_ready;
    logic [19:0] table_base;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        walk_done;
    logic        walk_abort;
    logic        abort_second;
    logic [19:0] out_ppn;
    logic [2:0]  out_rights;
    logic        out_dirty;
    logic [31:0] out_paddr;

    int checks = 0;
    int errors = 0;

    // memory model state
    logic [31:0] sup_word, sec_word;
    int          lat;
    int          req_cnt;
    logic [31:0] addr_log [0:1];
    int          hold_err;

    // captured result
    logic        got_done, got_abort, got_sec;
    logic [19:0] got_ppn;
    logic [2:0]  got_rights;
    logic        got_dirty;
    logic [31:0] got_paddr;

    always #4 clk = ~clk;

    ptw_walker dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
        .table_base(table_base),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .walk_done(walk_done), .walk_abort(walk_abort), .abort_second(abort_second),
        .out_ppn(out_ppn), .out_rights(out_rights), .out_dirty(out_dirty),
        .out_paddr(out_paddr)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // memory responder
    initial begin
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        req_cnt    = 0;
        hold_err   = 0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (mem_req) begin
                automatic logic [31:0] a = mem_addr;
                if (req_cnt < 2) addr_log[req_cnt] = a;
                req_cnt++;
                repeat (lat) begin
                    @(negedge clk);
                    if (mem_addr !== a) hold_err++;
                end
                mem_rdata  = (req_cnt == 1) ? sup_word : sec_word;
                mem_rvalid = 1'b1;
            end
        end
    end

    function automatic logic [31:0] exp_sup(input logic [31:0] v);
        return {table_base, v[31:22], 2'b00};
    endfunction

    function automatic logic [31:0] exp_sec(input logic [31:0] v);
        return {sup_word[31:12], v[21:12], 2'b00};
    endfunction

    // issue one walk, wait for its outcome, check the pulse lasts one cycle
    task automatic run_walk(input logic [31:0] v, input int busy_pokes);
        int n;
        while (!req_ready) @(negedge clk);
        req_cnt   = 0;
        hold_err  = 0;
        req_valid = 1'b1;
        req_vaddr = v;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < busy_pokes; i++) begin
            req_valid = 1'b1;
            req_vaddr = ~v;
            @(negedge clk);
        end
        req_valid = 1'b0;
        req_vaddr = v;
        n = 0;
        while (!walk_done && !walk_abort && n < 200) begin
            @(negedge clk);
            n++;
        end
        got_done   = walk_done;
        got_abort  = walk_abort;
        got_sec    = abort_second;
        got_ppn    = out_ppn;
        got_rights = out_rights;
        got_dirty  = out_dirty;
        got_paddr  = out_paddr;
        check(got_done ^ got_abort, "R7 one outcome", {30'd0, got_done, got_abort}, 32'h1);
        @(negedge clk);
        check(!walk_done && !walk_abort, "R7 single-cycle pulse",
              {30'd0, walk_done, walk_abort}, 32'h0);
        check(hold_err == 0, "R9 address held until rvalid", hold_err, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        req_valid = 1'b0;
        req_vaddr = '0;
        repeat (3) @(negedge clk);
        check(req_ready && !mem_req && !walk_done && !walk_abort, "R1 during reset",
              {28'd0, req_ready, mem_req, walk_done, walk_abort}, 32'h8);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !mem_req && !walk_done && !walk_abort, "R1 after reset",
              {28'd0, req_ready, mem_req, walk_done, walk_abort}, 32'h8);
    endtask

    task automatic t_good_walk;
        logic [31:0] v = 32'hABC1_2345;
        table_base = 20'h12345;
        sup_word = 32'h000F_F001;
        sec_word = 32'h7654_300B; // rights 101, dirty 0, present 1
        lat = 1;
        run_walk(v, 0);
        check(addr_log[0] == exp_sup(v), "R2 super read address", addr_log[0], exp_sup(v));
        check(addr_log[1] == exp_sec(v), "R4 second read address", addr_log[1], exp_sec(v));
        check(got_done, "R6 done raised", {31'd0, got_done}, 1);
        check(got_ppn == 20'h76543, "R6 page number", {12'd0, got_ppn}, 32'h76543);
        check(got_rights == 3'b101 && !got_dirty, "R6 rights and dirty",
              {28'd0, got_dirty, got_rights}, 32'h5);
        check(got_paddr == 32'h7654_3345, "R6 physical address", got_paddr, 32'h7654_3345);
    endtask

    task automatic t_super_abort;
        logic [31:0] v = 32'h0040_1FFF;
        table_base = 20'hFFFFF;
        sup_word = 32'hAAAA_A01E; // present bit clear
        sec_word = 32'h1111_1001;
        lat = 3;
        run_walk(v, 0);
        check(addr_log[0] == exp_sup(v), "R2 super address at top of table", addr_log[0],
              exp_sup(v));
        check(got_abort && !got_sec, "R3 abort from super level",
              {30'd0, got_abort, got_sec}, 32'h2);
        repeat (4) @(negedge clk);
        check(req_cnt == 1, "R3 no second read", req_cnt, 1);
    endtask

    task automatic t_second_abort;
        logic [31:0] v = 32'hFFFF_F000;
        table_base = 20'h00000;
        sup_word = 32'h5555_5001;
        sec_word = 32'hFFFF_FFFE; // present bit clear
        lat = 2;
        run_walk(v, 0);
        check(addr_log[1] == exp_sec(v), "R4 second address from super frame", addr_log[1],
              exp_sec(v));
        check(got_abort && got_sec, "R5 abort from second level",
              {30'd0, got_abort, got_sec}, 32'h3);
        check(req_cnt == 2, "R5 two reads made", req_cnt, 2);
    endtask

    task automatic t_slow_dirty;
        logic [31:0] v = 32'h1234_5ABC;
        table_base = 20'h0A0A0;
        sup_word = 32'h0BEE_F003;
        sec_word = 32'hCAFE_D01F; // rights 111, dirty 1
        lat = 7;
        run_walk(v, 0);
        check(got_done && got_ppn == 20'hCAFED, "R6 slow memory page number",
              {12'd0, got_ppn}, 32'hCAFED);
        check(got_rights == 3'b111 && got_dirty, "R6 dirty page fields",
              {28'd0, got_dirty, got_rights}, 32'hF);
        check(addr_log[1] == exp_sec(v), "R9 second address under long latency",
              addr_log[1], exp_sec(v));
    endtask

    task automatic t_busy_ignore;
        logic [31:0] v = 32'h8765_4321;
        table_base = 20'h33333;
        sup_word = 32'h0000_1001;
        sec_word = 32'h2468_A005;
        lat = 5;
        run_walk(v, 4);
        check(got_done && got_paddr == 32'h2468_A321, "R8 result from first request",
              got_paddr, 32'h2468_A321);
        check(addr_log[0] == exp_sup(v), "R8 busy request did not redirect", addr_log[0],
              exp_sup(v));
        repeat (6) @(negedge clk);
        check(req_cnt == 2 && req_ready, "R8 no extra walk started", req_cnt, 2);
    endtask

    initial begin
        table_base = '0;
        sup_word = '0;
        sec_word = '0;
        lat = 1;
        t_reset();
        t_good_walk();
        t_super_abort();
        t_second_abort();
        t_slow_dirty();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule